// File: doc/BRIEF.md
# Reference Frequency Lock Detector

This block decides whether a receive clock recovery loop may trust the serial data it is following, or must steer back to the local reference. It runs entirely on the reference clock. It times a fixed window of `2^WIN_LOG2` reference cycles. At each window boundary it samples a free-running count of recovered-clock edges, which is brought into the reference domain upstream. From the window it takes the absolute difference between the recovered edges and the reference cycles. This count stands for the frequency offset: with the default 65536-cycle window, one count is about 15.3 ppm.

The offset goes into a two-state lock decision with hysteresis. Leaving Unlocked needs a tight offset. Staying Locked tolerates an offset twice as large. Each state has a middle band in which the state is held. A second output grants lock-to-data only while the detector is Locked and the last offset was within the data tolerance (about 400 ppm, 26 counts by default). Both outputs are registered and change at most once per window.

Top module: `ref_freq_lock_det`

## Requirements
- R1: While `rst_n` is low and after its release, `locked` and `data_lock_ok` are 0 until a measurement says otherwise.
- R2: The first window boundary after reset only records a baseline of `rec_cnt`. No state change follows it, whatever `rec_cnt` holds.
- R3: From Unlocked, an offset below `ACQ_LO` counts (16) sets `locked` to 1.
- R4: From Unlocked, an offset from `ACQ_LO` to `ACQ_HI` counts inclusive (16 to 24) leaves the state unchanged.
- R5: From Unlocked, an offset above `ACQ_HI` (24) keeps `locked` at 0.
- R6: From Locked, an offset below `HOLD_LO` (32) keeps `locked` at 1.
- R7: From Locked, an offset from `HOLD_LO` to `HOLD_HI` inclusive (32 to 48) leaves the state unchanged.
- R8: From Locked, an offset above `HOLD_HI` (48) clears `locked`.
- R9: The offset is the magnitude of the difference. A recovered clock that is slow by N counts is judged the same as one that is fast by N counts.
- R10: `data_lock_ok` is 1 only when `locked` is 1 and the last offset was at most `DATA_TOL` (26) counts.
- R11: The outputs update only in the cycle after a window boundary, and they hold steady for the rest of the window.
- R12: The edge count is treated modulo `2^CNT_W`, so a window in which `rec_cnt` wraps past zero measures correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; all logic runs on it |
| rst_n | input | 1 | Active-low synchronous reset |
| rec_cnt | input | CNT_W | Free-running recovered-clock edge count, already synchronized to `clk` |
| locked | output | 1 | Lock state: 1 Locked, 0 Unlocked |
| data_lock_ok | output | 1 | Permission to follow the serial data |

## Verification
Two functions can fall in the same cycle: a window closing and `rec_cnt` wrapping past zero. The bench provokes this by using a 12-bit count with a 256-cycle window, so the count wraps partway through a long sequence of windows. The offset of the wrapping window must come out equal to the offset injected. The state decision in that cycle is judged against the same model as any other window. A second coincidence is checked in every window: the lock update and the permission update happen in one cycle. Each boundary is judged on the pair of outputs together.

// File: rtl/ref_lock_pkg.sv
package ref_lock_pkg;

  typedef enum logic {
    LK_OFF = 1'b0,
    LK_ON  = 1'b1
  } lk_state_t;

  // Offset band relative to the pair of thresholds in force for a state.
  typedef enum logic [1:0] {
    BAND_TIGHT = 2'd0,
    BAND_GREY  = 2'd1,
    BAND_WIDE  = 2'd2
  } band_t;

  function automatic band_t classify(input int unsigned mag,
                                     input int unsigned lo,
                                     input int unsigned hi);
    if (mag < lo)       return BAND_TIGHT;
    else if (mag <= hi) return BAND_GREY;
    else                return BAND_WIDE;
  endfunction

endpackage

// File: rtl/lk_window_timer.sv
module lk_window_timer #(
  parameter int WIN_LOG2 = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  logic [WIN_LOG2-1:0] cyc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cyc_q <= '0;
    else        cyc_q <= cyc_q + 1'b1;
  end

  assign tick = &cyc_q;

  // R11
  tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/lk_offset_meas.sv
module lk_offset_meas #(
  parameter int WIN_LOG2 = 16,
  parameter int CNT_W    = 20,
  parameter int DEV_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] rec_cnt,
  output logic             dev_vld,
  output logic [DEV_W-1:0] dev_mag
);
  localparam logic [CNT_W-1:0] WIN_CNT = CNT_W'(1) << WIN_LOG2;
  localparam logic [CNT_W-1:0] DEV_SAT = CNT_W'((64'd1 << DEV_W) - 64'd1);

  logic [CNT_W-1:0] base_q;
  logic             primed_q;
  logic [CNT_W-1:0] span;
  logic [CNT_W-1:0] off_raw;
  logic [CNT_W-1:0] off_abs;
  logic [DEV_W-1:0] off_sat;

  // Modular span: a wrap of rec_cnt inside the window cancels out (R12).
  assign span    = rec_cnt - base_q;
  assign off_raw = span - WIN_CNT;
  assign off_abs = off_raw[CNT_W-1] ? (~off_raw + 1'b1) : off_raw;
  assign off_sat = (off_abs > DEV_SAT) ? DEV_SAT[DEV_W-1:0] : off_abs[DEV_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q   <= '0;
      primed_q <= 1'b0;
      dev_vld  <= 1'b0;
      dev_mag  <= '0;
    end else begin
      dev_vld <= tick && primed_q;
      if (tick) begin
        base_q   <= rec_cnt;
        primed_q <= 1'b1;
        if (primed_q) dev_mag <= off_sat;
      end
    end
  end

  // R2
  no_first_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !primed_q) |=> !dev_vld);

  // R11
  meas_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_vld |=> !dev_vld);

  // R11
  mag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(dev_mag));

endmodule

// File: rtl/lk_hyst_fsm.sv
module lk_hyst_fsm
  import ref_lock_pkg::*;
#(
  parameter int DEV_W    = 8,
  parameter int ACQ_LO   = 16,
  parameter int ACQ_HI   = 24,
  parameter int HOLD_LO  = 32,
  parameter int HOLD_HI  = 48,
  parameter int DATA_TOL = 26
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dev_vld,
  input  logic [DEV_W-1:0] dev_mag,
  output logic             locked,
  output logic             data_ok
);
  lk_state_t state_q, state_d;
  band_t     band;
  logic      ok_d;

  always_comb begin
    state_d = state_q;
    if (state_q == LK_OFF)
      band = classify(int'(dev_mag), ACQ_LO, ACQ_HI);
    else
      band = classify(int'(dev_mag), HOLD_LO, HOLD_HI);
    if (dev_vld) begin
      unique case (band)
        BAND_TIGHT: state_d = LK_ON;
        BAND_WIDE:  state_d = LK_OFF;
        default:    state_d = state_q;
      endcase
    end
    ok_d = (state_d == LK_ON) && (int'(dev_mag) <= DATA_TOL);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= LK_OFF;
      data_ok <= 1'b0;
    end else if (dev_vld) begin
      state_q <= state_d;
      data_ok <= ok_d;
    end
  end

  assign locked = (state_q == LK_ON);

  // R3
  acquire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_vld && !locked && int'(dev_mag) < ACQ_LO) |=> locked);

  // R4
  acq_grey_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_vld && !locked && int'(dev_mag) >= ACQ_LO) |=> !locked);

  // R6
  keep_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_vld && locked && int'(dev_mag) <= HOLD_HI) |=> locked);

  // R8
  drop_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_vld && locked && int'(dev_mag) > HOLD_HI) |=> !locked);

  // R10
  ok_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_ok |-> locked);

  // R11
  quiet_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_vld |=> ($stable(locked) && $stable(data_ok)));

endmodule

// File: rtl/ref_freq_lock_det.sv
module ref_freq_lock_det #(
  parameter int WIN_LOG2 = 16,
  parameter int CNT_W    = 20,
  parameter int DEV_W    = 8,
  parameter int ACQ_LO   = 16,
  parameter int ACQ_HI   = 24,
  parameter int HOLD_LO  = 32,
  parameter int HOLD_HI  = 48,
  parameter int DATA_TOL = 26
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] rec_cnt,
  output logic             locked,
  output logic             data_lock_ok
);
  logic             tick;
  logic             dev_vld;
  logic [DEV_W-1:0] dev_mag;

  lk_window_timer #(.WIN_LOG2(WIN_LOG2)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick)
  );

  lk_offset_meas #(
    .WIN_LOG2 (WIN_LOG2),
    .CNT_W    (CNT_W),
    .DEV_W    (DEV_W)
  ) u_meas (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .rec_cnt (rec_cnt),
    .dev_vld (dev_vld),
    .dev_mag (dev_mag)
  );

  lk_hyst_fsm #(
    .DEV_W    (DEV_W),
    .ACQ_LO   (ACQ_LO),
    .ACQ_HI   (ACQ_HI),
    .HOLD_LO  (HOLD_LO),
    .HOLD_HI  (HOLD_HI),
    .DATA_TOL (DATA_TOL)
  ) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .dev_vld (dev_vld),
    .dev_mag (dev_mag),
    .locked  (locked),
    .data_ok (data_lock_ok)
  );

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> (!locked && !data_lock_ok));

endmodule

// File: tb/ref_freq_lock_det_tb.sv
module ref_freq_lock_det_tb;
  localparam int W_LOG = 8;
  localparam int W     = 1 << W_LOG;
  localparam int CW    = 12;
  localparam int NW    = 24;

  typedef struct {
    bit    lk;
    bit    ok;
    string tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] rec_cnt = '0;
  logic          locked, data_lock_ok;

  int   pos_n = 0;
  int   n_chk = 0;
  int   n_err = 0;
  bit   done  = 1'b0;
  int   ext [NW];
  exp_t q [$];
  exp_t cur;

  always #5 clk = ~clk;

  ref_freq_lock_det #(.WIN_LOG2(W_LOG), .CNT_W(CW)) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .rec_cnt      (rec_cnt),
    .locked       (locked),
    .data_lock_ok (data_lock_ok)
  );

  always @(posedge clk) if (rst_n) pos_n <= pos_n + 1;

  // Edge-count stimulus: one edge per reference cycle plus the window's offset mid-window.
  always @(negedge clk) begin
    if (rst_n && pos_n >= 1) begin
      if ((pos_n % W) == W / 2 && (pos_n / W) < NW)
        rec_cnt <= rec_cnt + CW'(1 + ext[pos_n / W]);
      else
        rec_cnt <= rec_cnt + 1'b1;
    end
  end

  task automatic check(input string tag, input bit lk_e, input bit ok_e);
    n_chk++;
    if (locked !== lk_e || data_lock_ok !== ok_e) begin
      n_err++;
      $display("FAIL %s: locked=%0b data_lock_ok=%0b, expected locked=%0b data_lock_ok=%0b",
               tag, locked, data_lock_ok, lk_e, ok_e);
    end
  endtask

  // Driver: fills offsets and pushes the expected outcome of every window.
  task automatic load_and_predict();
    int vals [NW] = '{0, 40, 20, 16, 24, 25, 15, 26, 27, 31, 32, 48,
                      -49, -10, -24, -33, 0, 49, -16, -15, -48, -60, 3, 0};
    bit lk = 1'b0;
    int end_prev = W - 1;
    int sum = 0;
    foreach (vals[i]) ext[i] = vals[i];
    q.push_back('{lk: 1'b0, ok: 1'b0, tag: "R2 baseline window"});
    sum = ext[0];
    end_prev = W - 1 + sum;
    for (int n = 2; n <= NW; n++) begin
      int    e = ext[n - 1];
      int    d = (e < 0) ? -e : e;
      int    end_n;
      string t;
      sum  += e;
      end_n = n * W - 1 + sum;
      if (!lk) begin
        if (d < 16)       begin lk = 1'b1; t = "R3"; end
        else if (d <= 24) t = "R4";
        else              t = "R5";
      end else begin
        if (d < 32)       t = "R6";
        else if (d <= 48) t = "R7";
        else begin lk = 1'b0; t = "R8"; end
      end
      t = {t, " R10"};
      if (e < 0) t = {t, " R9"};
      if ((end_n / (1 << CW)) != (end_prev / (1 << CW))) t = {t, " R12 wrap"};
      end_prev = end_n;
      q.push_back('{lk: lk, ok: lk && (d <= 26),
                    tag: $sformatf("%s window %0d offset %0d", t, n, e)});
    end
  endtask

  // Monitor: compares two cycles after each boundary, and rechecks mid-window.
  always @(negedge clk) begin
    if (rst_n && pos_n >= W) begin
      if ((pos_n % W) == 2 && (pos_n / W) <= NW) begin
        if (q.size() == 0) begin
          n_chk++; n_err++;
          $display("FAIL scoreboard: result with no expected item (actual locked=%0b, expected none)", locked);
        end else begin
          cur = q.pop_front();
          check(cur.tag, cur.lk, cur.ok);
        end
      end else if ((pos_n % W) == W / 2 && (pos_n / W) <= NW) begin
        check({"R11 mid-window hold after ", cur.tag}, cur.lk, cur.ok);
      end
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    load_and_predict();
    repeat (3) @(negedge clk);
    check("R1 during reset", 1'b0, 1'b0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check("R1 after release", 1'b0, 1'b0);
    wait (pos_n >= NW * W + 3);
    @(negedge clk);
    n_chk++;
    if (q.size() != 0) begin
      n_err++;
      $display("FAIL scoreboard: %0d expected items left, expected 0", q.size());
    end
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: run hung at cycle %0d, expected end by %0d", pos_n, NW * W + 3);
      finish_run();
    end
  end

endmodule